// File: doc/BRIEF.md
# Idle-Aware Transaction Gate with Wake Pulse

This block sits between a transaction source and an SPI transaction master that talks to a slave which falls asleep when the bus is quiet. It keeps a millisecond time base, which a programmable clock prescaler drives. It records the moment each transaction ends and the moment each one was granted. When the next request arrives, the block first holds it until a minimum turnaround gap has passed since the previous end.

Next the block checks whether the slave has been left alone for longer than the sleep threshold. The idle time is counted from the last grant. If the threshold has passed, the block raises a chip-select override for a fixed pulse time. During this pulse the master drives chip select but sends no clock. The block then waits a start-up interval before it grants the request.

The request side is a valid/ready pair. `req` is the valid and `gnt` is the ready, and a transaction starts on the clock where both are high. Back-pressure works this way: the source holds `req` high until the handshake, and the block holds `gnt` high until it sees `req`. After the handshake, `gnt` stays low until the master pulses `done` and the next set of timing rules has been met. The three delays and the prescaler are plain registers written through a small write port.

Top module: `spi_wake_guard`

## Requirements
- R1: After reset `gnt` and `cs_wake` are low. The stored end time and grant time are both 0 ms, and the gap, sleep, start-up and prescaler registers hold their parameter defaults. A request decided less than the sleep threshold after reset is therefore granted with no wake pulse.
- R2: The millisecond counter advances once every prescaler-value clocks. A request first seen when the counter reads R is decided when the counter reads max(R, L + GAP). L is the counter value on the clock that accepted the last `done`.
- R3: A wake pulse is issued exactly when the decision time minus G is at least SLEEP. G is the counter value on the clock of the last handshake. Otherwise `gnt` rises directly at the decision.
- R4: `cs_wake` rises at the decision and stays high until the counter has advanced PULSE_MS past the decision time. `gnt` stays low for the whole pulse.
- R5: After `cs_wake` falls, `gnt` stays low until the counter has advanced START past the value it had when the pulse ended. Only then does `gnt` rise.
- R6: Once high, `gnt` stays high until `req` is seen. After the handshake clock, `gnt` stays low while the transaction is busy. A `done` pulse that arrives when no transaction is busy is ignored and does not move L.
- R7: A write with `cfg_we` high stores `cfg_wdata` in one register, chosen by `cfg_addr`: 0 is the gap, 1 is the sleep threshold, 2 is the start-up wait and 3 is the clocks per millisecond (0 acts as 1). A write to address 3 restarts the prescaler phase without a tick. New values apply from the next clock.
- R8: Timing stays correct when the counter wraps. An idle time longer than the counter range still causes a wake pulse and still meets the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request for a new transaction (valid) |
| gnt | output | 1 | Transaction may start (ready) |
| done | input | 1 | One-clock strobe from the master at the end of a transaction |
| cs_wake | output | 1 | Chip-select override: hold chip select active with no clock |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select: 0 gap, 1 sleep, 2 start-up, 3 clocks per ms |
| cfg_wdata | input | TS_W | Register write data |

## Verification
The bench sweeps the amount of busy time across the sleep threshold one millisecond at a time, because a design with the compare off by one would wake the slave a millisecond early or late. It also sweeps the gap over several values, and it asserts requests both before and after the gap expires, because a design that measured the gap from the grant, or from the request, would grant at the wrong millisecond. A `done` strobe sent while the block is idle checks that the end time is not overwritten, which would otherwise push the next grant later. A long idle that spans more than one counter wrap checks that the sticky elapsed flags still force the wake and meet the gap; a plain modular compare would skip the wake there.

// File: rtl/swg_pkg.sv
package swg_pkg;
  typedef enum logic [2:0] {
    SW_IDLE,
    SW_PULSE,
    SW_START,
    SW_READY,
    SW_BUSY
  } swg_state_e;

  localparam int NUM_REGS = 4;
  localparam logic [1:0] REG_GAP   = 2'd0;
  localparam logic [1:0] REG_SLEEP = 2'd1;
  localparam logic [1:0] REG_START = 2'd2;
  localparam logic [1:0] REG_DIV   = 2'd3;
endpackage

// File: rtl/swg_regs.sv
module swg_regs
  import swg_pkg::*;
#(
  parameter int W         = 16,
  parameter int DIV_DEF   = 50000,
  parameter int GAP_DEF   = 2,
  parameter int SLEEP_DEF = 1000,
  parameter int START_DEF = 60
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] gap,
  output logic [W-1:0] sleep,
  output logic [W-1:0] start,
  output logic [W-1:0] div,
  output logic         div_wr
);
  localparam logic [W-1:0] RESET_VAL [NUM_REGS] =
    '{W'(GAP_DEF), W'(SLEEP_DEF), W'(START_DEF), W'(DIV_DEF)};

  logic [W-1:0] val [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) val[i] <= RESET_VAL[i];
    end else if (we) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (addr == 2'(i)) val[i] <= wdata;
    end
  end

  assign gap    = val[REG_GAP];
  assign sleep  = val[REG_SLEEP];
  assign start  = val[REG_START];
  assign div    = val[REG_DIV];
  assign div_wr = we && (addr == REG_DIV);
endmodule

// File: rtl/swg_timebase.sv
module swg_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div,
  input  logic         restart,
  output logic [W-1:0] now_ms
);
  logic [W-1:0] cnt;
  logic [W-1:0] lim;

  // a divider of zero behaves as one clock per millisecond
  assign lim = (div == '0) ? '0 : div - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      now_ms <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (cnt >= lim) begin
      cnt    <= '0;
      now_ms <= now_ms + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/swg_seq.sv
module swg_seq
  import swg_pkg::*;
#(
  parameter int W        = 16,
  parameter int PULSE_MS = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic         done,
  input  logic [W-1:0] now_ms,
  input  logic [W-1:0] gap,
  input  logic [W-1:0] sleep,
  input  logic [W-1:0] start,
  output logic         gnt,
  output logic         cs_wake
);
  localparam logic [W-1:0] PULSE_LEN = W'(PULSE_MS);

  swg_state_e   st;
  logic [W-1:0] last_end;
  logic [W-1:0] last_gnt;
  logic [W-1:0] mark;
  logic         gap_met;
  logic         asleep;

  logic [W-1:0] since_end;
  logic [W-1:0] since_gnt;
  logic [W-1:0] since_mark;
  logic         gap_ok;
  logic         wake_due;
  logic         take;

  // modular differences stay exact for spans below the counter range;
  // the sticky flags cover longer spans
  assign since_end  = now_ms - last_end;
  assign since_gnt  = now_ms - last_gnt;
  assign since_mark = now_ms - mark;
  assign gap_ok     = gap_met || (since_end >= gap);
  assign wake_due   = asleep || (since_gnt >= sleep);
  assign take       = (st == SW_READY) && req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SW_IDLE;
      last_end <= '0;
      last_gnt <= '0;
      mark     <= '0;
      gap_met  <= 1'b0;
    end else begin
      case (st)
        SW_IDLE: begin
          if (since_end >= gap) gap_met <= 1'b1;
          if (req && gap_ok) begin
            if (wake_due) begin
              st   <= SW_PULSE;
              mark <= now_ms;
            end else begin
              st <= SW_READY;
            end
          end
        end
        SW_PULSE: begin
          if (since_mark >= PULSE_LEN) begin
            st   <= SW_START;
            mark <= now_ms;
          end
        end
        SW_START: begin
          if (since_mark >= start) st <= SW_READY;
        end
        SW_READY: begin
          if (req) begin
            st       <= SW_BUSY;
            last_gnt <= now_ms;
          end
        end
        SW_BUSY: begin
          if (done) begin
            st       <= SW_IDLE;
            last_end <= now_ms;
            gap_met  <= 1'b0;
          end
        end
        default: st <= SW_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                asleep <= 1'b0;
    else if (take)             asleep <= 1'b0;
    else if (since_gnt >= sleep) asleep <= 1'b1;
  end

  assign gnt     = (st == SW_READY);
  assign cs_wake = (st == SW_PULSE);
endmodule

// File: rtl/spi_wake_guard.sv
module spi_wake_guard #(
  parameter int TS_W      = 16,
  parameter int DIV_DEF   = 50000,
  parameter int GAP_DEF   = 2,
  parameter int SLEEP_DEF = 1000,
  parameter int START_DEF = 60,
  parameter int PULSE_MS  = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  output logic            gnt,
  input  logic            done,
  output logic            cs_wake,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_addr,
  input  logic [TS_W-1:0] cfg_wdata
);
  logic [TS_W-1:0] gap_r, sleep_r, start_r, div_r, now_ms;
  logic            div_wr;

  swg_regs #(
    .W(TS_W), .DIV_DEF(DIV_DEF), .GAP_DEF(GAP_DEF),
    .SLEEP_DEF(SLEEP_DEF), .START_DEF(START_DEF)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .gap(gap_r), .sleep(sleep_r),
    .start(start_r), .div(div_r), .div_wr(div_wr)
  );

  swg_timebase #(.W(TS_W)) u_time (
    .clk(clk), .rst_n(rst_n), .div(div_r),
    .restart(div_wr), .now_ms(now_ms)
  );

  swg_seq #(.W(TS_W), .PULSE_MS(PULSE_MS)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done),
    .now_ms(now_ms), .gap(gap_r), .sleep(sleep_r), .start(start_r),
    .gnt(gnt), .cs_wake(cs_wake)
  );
endmodule

// File: rtl/swg_chk.sv
module swg_chk (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic gnt,
  input logic cs_wake
);
  assert_pulse_blocks_grant_R4: assert property (
    @(posedge clk) disable iff (!rst_n) !(gnt && cs_wake));

  assert_grant_held_R6: assert property (
    @(posedge clk) disable iff (!rst_n) (gnt && !req) |=> gnt);

  assert_grant_taken_R6: assert property (
    @(posedge clk) disable iff (!rst_n) (gnt && req) |=> !gnt);

  assert_start_wait_R5: assert property (
    @(posedge clk) disable iff (!rst_n) $fell(cs_wake) |-> !gnt);

  assert_wake_on_request_R3: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(cs_wake) |-> $past(req));
endmodule

bind spi_wake_guard swg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .cs_wake(cs_wake)
);

// File: tb/spi_wake_guard_test.sv
module spi_wake_guard_test;
  localparam int TS_W  = 7;
  localparam int DIV0  = 5;
  localparam int GAP0  = 2;
  localparam int SLP0  = 20;
  localparam int STR0  = 3;
  localparam int PULSE = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic done = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [TS_W-1:0] cfg_wdata = '0;
  logic gnt, cs_wake;

  always #10 clk = ~clk;

  spi_wake_guard #(
    .TS_W(TS_W), .DIV_DEF(DIV0), .GAP_DEF(GAP0),
    .SLEEP_DEF(SLP0), .START_DEF(STR0), .PULSE_MS(PULSE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .done(done),
    .cs_wake(cs_wake), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // millisecond model built from R2 and R7, unbounded so wrap does not matter
  int m_ms = 0, m_cnt = 0, m_div = DIV0, prev_ms = 0;
  int gap = GAP0, slp = SLP0, stw = STR0;
  int last_end = 0, last_gnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ms = 0; m_cnt = 0; m_div = DIV0;
    end else if (cfg_we && cfg_addr == 2'd3) begin
      m_div = (cfg_wdata == 0) ? 1 : int'(cfg_wdata);
      m_cnt = 0;
    end else if (m_cnt >= m_div - 1) begin
      m_cnt = 0; m_ms++;
    end else begin
      m_cnt++;
    end
  end

  task automatic step();
    prev_ms = m_ms;
    @(negedge clk);
  endtask

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic wr(int a, int v);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = TS_W'(v);
    step();
    cfg_we = 1'b0;
    if (a == 0) gap = v;
    if (a == 1) slp = v;
    if (a == 2) stw = v;
  endtask

  task automatic xact(int delay_cyc, int busy_ms, string tag);
    int r, x, ex_wake, n, m1;
    repeat (delay_cyc) step();
    req = 1'b1;
    r = m_ms;
    x = (r > last_end + gap) ? r : last_end + gap;
    ex_wake = ((x - last_gnt) >= slp) ? 1 : 0;
    n = 0;
    do begin step(); n++; end while (!gnt && !cs_wake && n < 5000);
    chk({tag, " R3 wake pulse issued"}, int'(cs_wake), ex_wake);
    chk({tag, " R2 decision ms"}, prev_ms, x);
    if (cs_wake) begin
      n = 0;
      while (cs_wake && n < 5000) begin
        if (gnt) chk({tag, " R4 grant during pulse"}, 1, 0);
        step(); n++;
      end
      m1 = prev_ms;
      chk({tag, " R4 pulse length ms"}, m1 - x, PULSE);
      chk({tag, " R5 grant low after pulse"}, int'(gnt), 0);
      n = 0;
      while (!gnt && n < 5000) begin step(); n++; end
      chk({tag, " R5 start-up wait ms"}, prev_ms - m1, stw);
    end
    last_gnt = m_ms;
    step();
    req = 1'b0;
    chk({tag, " R6 grant dropped after handshake"}, int'(gnt), 0);
    n = 0;
    while (m_ms < last_gnt + busy_ms && n < 50000) begin step(); n++; end
    chk({tag, " R6 grant low while busy"}, int'(gnt), 0);
    done = 1'b1;
    last_end = m_ms;
    step();
    done = 1'b0;
  endtask

  initial begin
    repeat (4) step();
    chk("R1 gnt in reset", int'(gnt), 0);
    chk("R1 cs_wake in reset", int'(cs_wake), 0);
    rst_n = 1'b1;
    step();
    chk("R1 gnt after reset", int'(gnt), 0);
    chk("R1 cs_wake after reset", int'(cs_wake), 0);
    xact(1, 5, "first R1");

    // gap sweep, request before and after expiry (R2, R7)
    for (int g = 1; g <= 4; g++) begin
      wr(0, g);
      xact(0, 3, "gap early R2 R7");
      xact(5 * (g + 2), 3, "gap late R2");
    end

    // wake boundary sweep around the sleep threshold (R3)
    wr(0, 2);
    for (int b = 16; b <= 19; b++) xact(0, b, "sleep edge R3");

    // new start-up and sleep values (R7, R5)
    wr(2, 5);
    wr(1, 10);
    xact(0, 12, "start R7 R5");
    xact(0, 4, "no wake R3");

    // idle across wraparound of the 7-bit counter (R8)
    repeat (900) step();
    xact(0, 2, "long idle R8");
    repeat (380) step();
    xact(0, 2, "wrap idle R8");

    // done outside a transaction is ignored (R6)
    wr(0, 15);
    while (m_ms < last_end + 3) step();
    done = 1'b1;
    step();
    done = 1'b0;
    xact(5, 2, "stray done R6");

    // prescaler rewrite (R7)
    wr(0, 2);
    wr(3, 3);
    xact(1, 4, "div3 R7");
    xact(0, 9, "div3 wake R7");
    wr(3, 0);
    xact(2, 3, "div0 R7");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule